// File: doc/BRIEF.md
# Flow-Through Burst SRAM Access Controller

This block is a cycle-level model of a common-I/O synchronous burst SRAM with a flow-through read path. The word is 36 bits wide, split into four 9-bit lanes. Each lane has 8 data bits and 1 parity bit. The array depth is a parameter. A host opens an access with one of two address strobes. A processor-side strobe always reads on its opening edge. A controller-side strobe may read or write on its opening edge. The access then either advances through a four-beat burst or holds its address.

The burst generator keeps the upper address bits and steps the two low bits. It follows either a linear order or an exclusive-OR (interleaved) order, chosen by a static mode input. Writes are decoded from three inputs:
- a global write that covers all lanes;
- a byte-write enable;
- one select per lane.

Read data appears in the same cycle as the edge that registered its address. The split data bus reports through a valid flag. Three things hold the flag low:
- an output enable that is high;
- any cycle after a write, until a new opening or an advance;
- the first read cycle after the block leaves the deselected state.

Top module: `fts_sram_ctrl`

## Requirements
- R1: A write is indicated only when `gw_n` is 0, or when `bwe_n` is 0 and at least one bit of `bsel_n` is 0. With `gw_n`=1 and `bwe_n`=1, or with `bwe_n`=0 and `bsel_n`=4'hF, no lane is written.
- R2: With `gw_n`=0 on a write-capable edge, all four lanes are written, whatever `bwe_n` and `bsel_n` are.
- R3: On a byte write, `bsel_n[i]`=0 writes lane i, which is word bits [9i+8:9i]. Bit 9i+8 is that lane's parity bit. Lanes whose select is 1 keep their old contents.
- R4: On an edge where `proc_stb_n`=0 and `sel1_n`=0, nothing is written and the access is a read, whatever the write inputs are.
- R5: An edge with `ctrl_stb_n`=0, `proc_stb_n`=1, all selects active and a write indicated writes `wdata` to `addr` on that edge. If both strobes are low, the processor strobe wins.
- R6: Flow-through read: after an edge that sets the access address, `rdata` carries that word before the next edge.
- R7: Burst order uses a base b (the low two bits of the opening address) and a beat count n. In linear mode (`interleave`=0) the low bits are (b+n) mod 4. In interleaved mode (`interleave`=1) they are b XOR n. `adv_n`=0 on a non-strobe edge advances n, and `adv_n`=1 holds the address. The upper address bits never change within an access.
- R8: After any write edge, `rvalid` is 0 and stays 0 until an opening edge or an advance edge occurs without a write. This holds even with `oe_n`=0.
- R9: On the first cycle after an opening read from the deselected state, `rvalid` is 0 even with `oe_n`=0. It is 1 from the next cycle on.
- R10: After a deselect edge, or while `oe_n`=1, `rvalid` is 0. Whenever `rvalid` is 0, `rdata` is 0.
- R11: Selection needs `sel1_n`=0, `sel2`=1 and `sel3_n`=0. With `sel1_n`=1 the processor strobe is ignored, so a running burst continues. A strobe seen while the selects are inactive deselects the block.
- R12: After reset the block is deselected and `rvalid` is 0. Lanes never written read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel1_n | input | 1 | Primary select, active low; also gates the processor strobe |
| sel2 | input | 1 | Expansion select, active high |
| sel3_n | input | 1 | Expansion select, active low |
| proc_stb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | AW | Opening word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, not sampled |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| wdata | input | 36 | Write word, four 9-bit lanes |
| rdata | output | 36 | Read word, 0 when not valid |
| rvalid | output | 1 | Read output is being driven |

## Verification
Each write lands on the edge where it is presented. Read data and `rvalid` for that edge are due in the same cycle, within a few nanoseconds after the edge. The one exception is `oe_n`, which acts with no edge at all.

The bench drives every input at the falling edge. For each cycle it queues exactly one expected item. A monitor takes that item off the queue two time units after the next rising edge, so each comparison sees only the edge under test.

The delayed effects are checked in the cycles where they fall:
- the one-cycle mask after deselect is checked on the cycle after the opening, and lifts on the cycle after that;
- the output blanking after a write is checked on the following suspend cycle and on the advance cycle that lifts it.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BEAT_W  = 2;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  function automatic beat_t beat_offset(beat_t base, beat_t step, burst_order_e order);
    beat_t off;
    if (order == ORDER_INTERLEAVE) off = base ^ step;
    else                           off = base + step;
    return off;
  endfunction

endpackage

// File: rtl/fts_burst_gen.sv
module fts_burst_gen
  import fts_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] load_addr,
  input  logic          interleave,
  output logic [AW-1:0] addr_nx,
  output logic [AW-1:0] addr_q
);

  localparam int HI_W = AW - BEAT_W;

  logic [HI_W-1:0] hi_q,   hi_d;
  beat_t           base_q, base_d;
  beat_t           step_q, step_d;
  burst_order_e    order;

  assign order = burst_order_e'(interleave);

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    step_d = step_q;
    if (load) begin
      hi_d   = load_addr[AW-1:BEAT_W];
      base_d = load_addr[BEAT_W-1:0];
      step_d = '0;
    end else if (advance) begin
      step_d = step_q + beat_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      step_q <= '0;
    end else if (load || advance) begin
      hi_q   <= hi_d;
      base_q <= base_d;
      step_q <= step_d;
    end
  end

  assign addr_nx = {hi_d, beat_offset(base_d, step_d, order)};
  assign addr_q  = {hi_q, beat_offset(base_q, step_q, order)};

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(addr_q)); // R7
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (addr_q[AW-1:BEAT_W] == $past(addr_q[AW-1:BEAT_W]))); // R7
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_q == $past(load_addr))); // R6

endmodule

// File: rtl/fts_wr_decode.sv
module fts_wr_decode
  import fts_pkg::*;
(
  input  logic       gw_n,
  input  logic       bwe_n,
  input  lane_mask_t bsel_n,
  output lane_mask_t lane_raw,
  output logic       wr_seen
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_raw[l] = !gw_n || (!bwe_n && !bsel_n[l]);
  end

  assign wr_seen = |lane_raw;

endmodule

// File: rtl/fts_store.sv
module fts_store
  import fts_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lane_mask_t    lane_we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rword
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cell_q [DEPTH];
    logic [DEPTH-1:0]  seen_q;

    always_ff @(posedge clk) begin
      if (lane_we[l]) cell_q[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seen_q        <= '0;
      else if (lane_we[l]) seen_q[waddr] <= 1'b1;
    end

    assign rword[l*LANE_W +: LANE_W] = seen_q[raddr] ? cell_q[raddr] : '0;
  end

endmodule

// File: rtl/fts_out_ctrl.sv
module fts_out_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic desel,
  input  logic advance,
  input  logic do_write,
  input  logic oe_n,
  output logic active_q,
  output logic drive_en
);

  logic active_d;
  logic hold_q, hold_d;
  logic mask_q, mask_d;

  always_comb begin
    active_d = active_q;
    if (start)      active_d = 1'b1;
    else if (desel) active_d = 1'b0;

    hold_d = hold_q;
    if (do_write)                        hold_d = 1'b1;
    else if (start || advance || desel)  hold_d = 1'b0;

    mask_d = start && !active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      hold_q   <= hold_d;
      mask_q   <= mask_d;
    end
  end

  assign drive_en = active_q && !hold_q && !mask_q && !oe_n;

  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> !drive_en); // R8
  AST_DESEL_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !drive_en); // R10
  AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active_q) |=> !drive_en); // R9

endmodule

// File: rtl/fts_sram_ctrl.sv
module fts_sram_ctrl
  import fts_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic [AW-1:0]     addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              oe_n,
  input  logic              interleave,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic       sel_ok, proc_seen, ctrl_seen, strobe;
  logic       start, desel, cont, advance, wr_allow, do_write;
  logic       active_q, drive_en, wr_seen;
  lane_mask_t lane_raw, lane_we;
  logic [AW-1:0] addr_nx, addr_q;
  word_t      rword;

  always_comb begin
    sel_ok    = !sel1_n && sel2 && !sel3_n;
    proc_seen = !proc_stb_n && !sel1_n;
    ctrl_seen = !proc_seen && !ctrl_stb_n;
    strobe    = proc_seen || ctrl_seen;
    start     = strobe && sel_ok;
    desel     = strobe && !sel_ok;
    cont      = !strobe && active_q;
    advance   = cont && !adv_n;
    wr_allow  = (ctrl_seen && sel_ok) || cont;
    do_write  = wr_allow && wr_seen;
    lane_we   = wr_allow ? lane_raw : '0;
  end

  fts_wr_decode u_dec (
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bsel_n   (bsel_n),
    .lane_raw (lane_raw),
    .wr_seen  (wr_seen)
  );

  fts_burst_gen #(.AW(AW)) u_burst (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load       (start),
    .advance    (advance),
    .load_addr  (addr),
    .interleave (interleave),
    .addr_nx    (addr_nx),
    .addr_q     (addr_q)
  );

  fts_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .lane_we (lane_we),
    .waddr   (addr_nx),
    .wdata   (wdata),
    .raddr   (addr_q),
    .rword   (rword)
  );

  fts_out_ctrl u_out (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .desel    (desel),
    .advance  (advance),
    .do_write (do_write),
    .oe_n     (oe_n),
    .active_q (active_q),
    .drive_en (drive_en)
  );

  assign rvalid = drive_en;
  assign rdata  = drive_en ? rword : '0;

  AST_PROC_EDGE_READ: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!proc_stb_n && !sel1_n) |-> (lane_we == '0)); // R4
  AST_GW_FULL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_allow && !gw_n) |-> (lane_we == '1)); // R2
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_allow && gw_n && !bwe_n) |-> (lane_we == ~bsel_n)); // R3
  AST_NO_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (gw_n && bwe_n) |-> (lane_we == '0)); // R1
  AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    oe_n |-> !rvalid); // R10
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rvalid |-> (rdata == '0)); // R10

endmodule

// File: tb/fts_sram_ctrl_tb.sv
module fts_sram_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel1_n, sel2, sel3_n;
  logic          proc_stb_n, ctrl_stb_n, adv_n;
  logic [AW-1:0] addr;
  logic          gw_n, bwe_n;
  logic [3:0]    bsel_n;
  logic          oe_n, interleave;
  logic [35:0]   wdata, rdata;
  logic          rvalid;

  logic s1_v = 1'b0, s2_v = 1'b1, s3_v = 1'b0, mode_v = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fts_sram_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .interleave(interleave), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct {
    bit          chk;
    bit          ev;
    logic [35:0] ed;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  localparam logic [35:0] W0 = 36'h1_2345_6789;
  localparam logic [35:0] W1 = 36'h2_468A_CE13;
  localparam logic [35:0] W2 = 36'h9_8765_4321;
  localparam logic [35:0] W3 = 36'h5_A5A5_5A5A;
  localparam logic [35:0] W4 = 36'hC_0FFE_E123;
  localparam logic [35:0] W5 = 36'hA_BCDE_F012;
  localparam logic [35:0] D8 = 36'h8_0000_0088;
  localparam logic [35:0] D9 = 36'h9_0000_0099;
  localparam logic [35:0] DA = 36'hA_0000_00AA;
  localparam logic [35:0] DB = 36'hB_0000_00BB;

  task automatic step(input logic ps, input logic cs, input logic adv,
                      input logic gw, input logic bwe, input logic [3:0] bs,
                      input logic oe, input logic [AW-1:0] a, input logic [35:0] wd,
                      input bit chk, input bit ev, input logic [35:0] ed, input string tag);
    exp_t it;
    @(negedge clk);
    proc_stb_n = ps; ctrl_stb_n = cs; adv_n = adv;
    gw_n = gw; bwe_n = bwe; bsel_n = bs; oe_n = oe;
    addr = a; wdata = wd;
    sel1_n = s1_v; sel2 = s2_v; sel3_n = s3_v; interleave = mode_v;
    it.chk = chk; it.ev = ev; it.ed = ed; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd_open(input logic [AW-1:0] a, input bit ev, input logic [35:0] ed, input string tag);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, a, '0, 1'b1, ev, ed, tag);
  endtask

  task automatic ctl_wr(input logic [AW-1:0] a, input logic gw, input logic bwe,
                        input logic [3:0] bs, input logic [35:0] wd, input string tag);
    step(1'b1, 1'b0, 1'b1, gw, bwe, bs, 1'b0, a, wd, 1'b1, 1'b0, '0, tag);
  endtask

  task automatic go(input logic adv, input logic gw, input logic bwe, input logic [3:0] bs,
                    input logic oe, input logic [35:0] wd, input bit ev, input logic [35:0] ed,
                    input string tag);
    step(1'b1, 1'b1, adv, gw, bwe, bs, oe, '0, wd, 1'b1, ev, ed, tag);
  endtask

  initial begin : monitor
    exp_t m_it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        m_it = q.pop_front();
        if (m_it.chk) begin
          n_run++;
          if (rvalid !== m_it.ev || rdata !== m_it.ed) begin
            n_fail++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     m_it.tag, rvalid, rdata, m_it.ev, m_it.ed);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0;
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF; oe_n = 1'b0;
    addr = '0; wdata = '0; sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; interleave = 1'b0;
    repeat (3) @(negedge clk);
    n_run++;
    if (rvalid !== 1'b0 || rdata !== 36'h0) begin
      n_fail++;
      $display("FAIL R12 reset: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Controller-opened global write, then read back.
    ctl_wr(4'd4, 1'b0, 1'b1, 4'hF, W0, "R5 ctrl write blanks output");
    rd_open(4'd4, 1'b1, W0, "R5_R6 read back ctrl write");

    // Processor opening edge ignores write inputs.
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 4'd5, W1, 1'b1, 1'b1, 36'h0, "R4_R12 proc open reads zero");
    go(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, W1, 1'b0, '0, "R8 suspend write blanks");
    go(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b0, '0, "R8 suspend read stays off");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, 36'h0, "R8 advance lifts blanking");
    rd_open(4'd5, 1'b1, W1, "R4 later edge wrote");

    // Byte lanes.
    ctl_wr(4'd6, 1'b1, 1'b0, 4'b1010, W2, "R3 byte write lanes 0,2");
    go(1'b1, 1'b1, 1'b0, 4'b0111, 1'b0, W5, 1'b0, '0, "R3 byte write lane 3");
    rd_open(4'd6, 1'b1, (W2 & 36'h0_07FC_01FF) | (W5 & 36'hF_F800_0000), "R3 lane merge");
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 4'd6, W4, 1'b1, 1'b1,
         (W2 & 36'h0_07FC_01FF) | (W5 & 36'hF_F800_0000), "R1 selects without enable");
    go(1'b1, 1'b1, 1'b0, 4'hF, 1'b0, W4, 1'b1,
       (W2 & 36'h0_07FC_01FF) | (W5 & 36'hF_F800_0000), "R1 enable without selects");
    ctl_wr(4'd7, 1'b0, 1'b1, 4'hF, W3, "R2 global write override");
    rd_open(4'd7, 1'b1, W3, "R2 all lanes written");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 4'd7, W4, 1'b1, 1'b1, W3, "R5 proc strobe wins");

    // Linear burst fill and read.
    ctl_wr(4'd9, 1'b0, 1'b1, 4'hF, D9, "R7 fill 9");
    go(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, DA, 1'b0, '0, "R7 fill 10");
    go(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, DB, 1'b0, '0, "R7 fill 11");
    go(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, D8, 1'b0, '0, "R7 fill 8");
    rd_open(4'd9, 1'b1, D9, "R7 linear beat 0");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, DA, "R7 linear beat 1");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, DB, "R7 linear beat 2");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, D8, "R7 linear beat 3 wraps low bits");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, D9, "R7 linear wraps to start");
    go(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, D9, "R7 suspend holds");

    // Interleaved burst from base 2.
    mode_v = 1'b1;
    rd_open(4'd10, 1'b1, DA, "R7 interleave beat 0");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, DB, "R7 interleave beat 1");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, D8, "R7 interleave beat 2");
    go(1'b0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, D9, "R7 interleave beat 3");

    // Deselect, first-read mask, output enable.
    s2_v = 1'b0;
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 4'd4, '0, 1'b1, 1'b0, '0, "R10_R11 deselect");
    s2_v = 1'b1;
    rd_open(4'd9, 1'b0, '0, "R9 first read masked");
    go(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, D9, "R9 mask lifts");
    go(1'b1, 1'b1, 1'b1, 4'hF, 1'b1, '0, 1'b0, '0, "R10 oe high");
    go(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b1, D9, "R10 oe low again");

    // Processor strobe ignored with primary select high.
    s1_v = 1'b1;
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 4'd4, '0, 1'b1, 1'b1, D8, "R11 proc strobe ignored");
    s1_v = 1'b0; s3_v = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 4'd4, '0, 1'b1, 1'b0, '0, "R11 select3 deselects");
    s3_v = 1'b0;
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, '0, '0, 1'b0, 1'b0, '0, "idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule